// File: doc/BRIEF.md
# Per-Core Interrupt Winner and Acknowledge

This block sits in front of a single processor core. Two sources offer it a candidate interrupt: a scanner over the shared interrupts, and a core-private source that owns software-generated, private-peripheral and message-based interrupts. The block holds one winner record of ID and priority. It raises the interrupt request line to the core when that record beats the priority mask. It also serves the core's acknowledge and end-of-interrupt operations.

An acknowledge returns the winner's ID, or the spurious ID when nothing is pending. It clears the record at once by forcing its priority to all-ones, and sends an activate or clear-pending command to the source that owns the ID. An end-of-interrupt sends a deactivate command to the owning source. Every acknowledge, every end-of-interrupt and every change pulse from a source starts a re-evaluation. A re-evaluation always runs in the same order: shared scan handshake, then private handshake, then a reload of the record from the better of the two candidates.

Acknowledge, acknowledge response, end-of-interrupt and command are valid/ready streams. A transfer happens on a rising edge where both valid and ready are high. A sender holds its payload stable while valid is high and ready is low. The block never drops valid before the transfer completes.

Top module: `core_irq_arbiter`

## Requirements
- R1: After reset, irq_out, ack_rsp_vld, cmd_vld and both scan requests are low, and ack_rdy is high.
- R2: A re-evaluation raises shr_scan_req until shr_scan_done, then prv_scan_req until prv_scan_done, then reloads the record. The private request never rises before the shared handshake completes.
- R3: On reload, the valid candidate with the lower priority value wins. On equal priority, the lower ID wins, whichever source it comes from. The record does not follow candidate changes between re-evaluations.
- R4: irq_out is high exactly when the record priority is not all-ones and is strictly below prio_mask.
- R5: An accepted acknowledge forces the record priority to all-ones, so irq_out is low from the next cycle until a reload.
- R6: An acknowledge of a live record issues one command. ID below 32: activate (cmd_op 1) to the private source (cmd_dst 0). ID 32 to 1019: activate to the shared source (cmd_dst 1). ID 8192 and above: clear-pending (cmd_op 3) to the private source. IDs 1020 to 8191 issue no command.
- R7: End-of-interrupt for ID below 32 sends deactivate (cmd_op 2) with cmd_dst 0. For ID 32 to 1019 it sends deactivate with cmd_dst 1. Other IDs send no command, but still cause a re-evaluation.
- R8: An acknowledge with no live record returns ID 1023, issues no command and still causes a re-evaluation.
- R9: A command or response held against a low ready keeps its payload stable. The shared scan does not begin until the command has transferred.
- R10: A src_kick that arrives while the shared or private handshake or the reload is in progress causes exactly one extra re-evaluation.
- R11: Acknowledge has precedence over end-of-interrupt: eoi_rdy is low whenever ack_vld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| shr_cand_vld | input | 1 | Shared candidate present |
| shr_cand_id | input | 16 | Shared candidate ID |
| shr_cand_prio | input | 8 | Shared candidate priority |
| prv_cand_vld | input | 1 | Private candidate present |
| prv_cand_id | input | 16 | Private candidate ID |
| prv_cand_prio | input | 8 | Private candidate priority |
| prio_mask | input | 8 | Priority mask; request needs a strictly lower priority |
| src_kick | input | 1 | A source changed state; request re-evaluation |
| shr_scan_req | output | 1 | Shared scan requested |
| shr_scan_done | input | 1 | Shared scan finished |
| prv_scan_req | output | 1 | Private evaluation requested |
| prv_scan_done | input | 1 | Private evaluation finished |
| irq_out | output | 1 | Interrupt request to the core |
| ack_vld | input | 1 | Acknowledge request valid |
| ack_rdy | output | 1 | Acknowledge request ready |
| ack_rsp_vld | output | 1 | Acknowledged ID valid |
| ack_rsp_rdy | input | 1 | Acknowledged ID ready |
| ack_rsp_id | output | 16 | Acknowledged ID |
| eoi_vld | input | 1 | End-of-interrupt valid |
| eoi_rdy | output | 1 | End-of-interrupt ready |
| eoi_id | input | 16 | End-of-interrupt ID |
| cmd_vld | output | 1 | Source command valid |
| cmd_rdy | input | 1 | Source command ready |
| cmd_op | output | 2 | 1 activate, 2 deactivate, 3 clear-pending |
| cmd_dst | output | 1 | 0 private source, 1 shared source |
| cmd_id | output | 16 | Command target ID |

## Verification
The response and any command appear in the cycle after the edge that accepts an acknowledge or end-of-interrupt. irq_out falls in that same cycle. The shared request follows one cycle after the command transfers. With scan sources that answer at once, the record reloads three edges after the shared request rises, and irq_out follows that reload combinationally. The bench drives inputs and samples outputs on falling edges. It waits a fixed settle margin longer than that chain before checking irq_out or the next response. It counts the rises of both scan requests to check their order and how many re-evaluations ran.

// File: rtl/cia_pkg.sv
package cia_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ACT   = 2'd1,
    OP_DEACT = 2'd2,
    OP_CLRP  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    CLS_PRIV,
    CLS_SHR,
    CLS_MSG,
    CLS_RSVD
  } id_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_SHR,
    ST_PRV,
    ST_UPD
  } seq_state_e;

  localparam logic DST_PRV = 1'b0;
  localparam logic DST_SHR = 1'b1;
endpackage

// File: rtl/cia_id_route.sv
module cia_id_route
  import cia_pkg::*;
#(
  parameter int ID_W      = 16,
  parameter int PRV_LIMIT = 32,
  parameter int RSVD_BASE = 1020,
  parameter int MSG_BASE  = 8192
) (
  input  logic [ID_W-1:0] id,
  output id_class_e       cls
);
  localparam logic [ID_W-1:0] LIM_PRV  = ID_W'(PRV_LIMIT);
  localparam logic [ID_W-1:0] LIM_RSVD = ID_W'(RSVD_BASE);
  localparam logic [ID_W-1:0] LIM_MSG  = ID_W'(MSG_BASE);

  always_comb begin
    if (id < LIM_PRV)       cls = CLS_PRIV;
    else if (id < LIM_RSVD) cls = CLS_SHR;
    else if (id >= LIM_MSG) cls = CLS_MSG;
    else                    cls = CLS_RSVD;
  end
endmodule

// File: rtl/cia_pick.sv
module cia_pick #(
  parameter int ID_W   = 16,
  parameter int PRIO_W = 8
) (
  input  logic              a_vld,
  input  logic [ID_W-1:0]   a_id,
  input  logic [PRIO_W-1:0] a_prio,
  input  logic              b_vld,
  input  logic [ID_W-1:0]   b_id,
  input  logic [PRIO_W-1:0] b_prio,
  output logic              w_vld,
  output logic [ID_W-1:0]   w_id,
  output logic [PRIO_W-1:0] w_prio
);
  logic a_better;

  always_comb begin
    a_better = 1'b0;
    if (a_vld) begin
      if (!b_vld)                  a_better = 1'b1;
      else if (a_prio < b_prio)    a_better = 1'b1;
      else if (a_prio == b_prio)   a_better = (a_id < b_id);
    end
    w_vld  = a_vld | b_vld;
    w_id   = a_better ? a_id   : b_id;
    w_prio = a_better ? a_prio : b_prio;
  end
endmodule

// File: rtl/cia_seq.sv
module cia_seq
  import cia_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_cmd,
  input  logic cmd_fire,
  input  logic kick,
  input  logic shr_done,
  input  logic prv_done,
  output logic idle,
  output logic shr_req,
  output logic prv_req,
  output logic upd
);
  seq_state_e st, st_nx;
  logic rerun, rerun_nx;

  always_comb begin
    st_nx    = st;
    rerun_nx = rerun;
    unique case (st)
      ST_IDLE: begin
        if (go)        st_nx = go_cmd ? ST_CMD : ST_SHR;
        else if (kick) st_nx = ST_SHR;
      end
      ST_CMD: if (cmd_fire) st_nx = ST_SHR;
      ST_SHR: begin
        if (kick) rerun_nx = 1'b1;
        if (shr_done) st_nx = ST_PRV;
      end
      ST_PRV: begin
        if (kick) rerun_nx = 1'b1;
        if (prv_done) st_nx = ST_UPD;
      end
      ST_UPD: begin
        st_nx    = (rerun || kick) ? ST_SHR : ST_IDLE;
        rerun_nx = 1'b0;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      rerun <= 1'b0;
    end else begin
      st    <= st_nx;
      rerun <= rerun_nx;
    end
  end

  assign idle    = (st == ST_IDLE);
  assign shr_req = (st == ST_SHR);
  assign prv_req = (st == ST_PRV);
  assign upd     = (st == ST_UPD);
endmodule

// File: rtl/core_irq_arbiter.sv
module core_irq_arbiter
  import cia_pkg::*;
#(
  parameter int ID_W        = 16,
  parameter int PRIO_W      = 8,
  parameter int PRV_LIMIT   = 32,
  parameter int RSVD_BASE   = 1020,
  parameter int MSG_BASE    = 8192,
  parameter int SPURIOUS_ID = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shr_cand_vld,
  input  logic [ID_W-1:0]   shr_cand_id,
  input  logic [PRIO_W-1:0] shr_cand_prio,
  input  logic              prv_cand_vld,
  input  logic [ID_W-1:0]   prv_cand_id,
  input  logic [PRIO_W-1:0] prv_cand_prio,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic              src_kick,
  output logic              shr_scan_req,
  input  logic              shr_scan_done,
  output logic              prv_scan_req,
  input  logic              prv_scan_done,
  output logic              irq_out,
  input  logic              ack_vld,
  output logic              ack_rdy,
  output logic              ack_rsp_vld,
  input  logic              ack_rsp_rdy,
  output logic [ID_W-1:0]   ack_rsp_id,
  input  logic              eoi_vld,
  output logic              eoi_rdy,
  input  logic [ID_W-1:0]   eoi_id,
  output logic              cmd_vld,
  input  logic              cmd_rdy,
  output logic [1:0]        cmd_op,
  output logic              cmd_dst,
  output logic [ID_W-1:0]   cmd_id
);
  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [ID_W-1:0]   ID_SPUR   = ID_W'(SPURIOUS_ID);

  // winner record
  logic [ID_W-1:0]   rec_id;
  logic [PRIO_W-1:0] rec_prio;
  logic              rec_live;

  logic              pk_vld;
  logic [ID_W-1:0]   pk_id;
  logic [PRIO_W-1:0] pk_prio;

  logic      seq_idle, seq_upd;
  logic      ack_fire, eoi_fire, cmd_fire, go, need_cmd;
  id_class_e rec_cls, eoi_cls;
  cmd_op_e   nx_op;
  logic      nx_dst;
  logic [ID_W-1:0] nx_id;

  cia_pick #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_pick (
    .a_vld (shr_cand_vld), .a_id (shr_cand_id), .a_prio (shr_cand_prio),
    .b_vld (prv_cand_vld), .b_id (prv_cand_id), .b_prio (prv_cand_prio),
    .w_vld (pk_vld),       .w_id (pk_id),       .w_prio (pk_prio)
  );

  cia_id_route #(.ID_W(ID_W), .PRV_LIMIT(PRV_LIMIT), .RSVD_BASE(RSVD_BASE),
                 .MSG_BASE(MSG_BASE)) u_rec_route (.id(rec_id), .cls(rec_cls));

  cia_id_route #(.ID_W(ID_W), .PRV_LIMIT(PRV_LIMIT), .RSVD_BASE(RSVD_BASE),
                 .MSG_BASE(MSG_BASE)) u_eoi_route (.id(eoi_id), .cls(eoi_cls));

  cia_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .go_cmd   (need_cmd),
    .cmd_fire (cmd_fire),
    .kick     (src_kick),
    .shr_done (shr_scan_done),
    .prv_done (prv_scan_done),
    .idle     (seq_idle),
    .shr_req  (shr_scan_req),
    .prv_req  (prv_scan_req),
    .upd      (seq_upd)
  );

  assign rec_live = (rec_prio != PRIO_IDLE);
  assign irq_out  = rec_live && (rec_prio < prio_mask);

  assign ack_rdy  = seq_idle && !ack_rsp_vld;
  assign eoi_rdy  = seq_idle && !ack_vld;
  assign ack_fire = ack_vld && ack_rdy;
  assign eoi_fire = eoi_vld && eoi_rdy;
  assign cmd_fire = cmd_vld && cmd_rdy;
  assign go       = ack_fire || eoi_fire;

  // command selection by owning source
  always_comb begin
    nx_op  = OP_NONE;
    nx_dst = DST_PRV;
    nx_id  = rec_id;
    if (ack_fire) begin
      if (rec_live) begin
        unique case (rec_cls)
          CLS_PRIV: begin nx_op = OP_ACT;  nx_dst = DST_PRV; end
          CLS_SHR:  begin nx_op = OP_ACT;  nx_dst = DST_SHR; end
          CLS_MSG:  begin nx_op = OP_CLRP; nx_dst = DST_PRV; end
          default:  nx_op = OP_NONE;
        endcase
      end
    end else if (eoi_fire) begin
      nx_id = eoi_id;
      unique case (eoi_cls)
        CLS_PRIV: begin nx_op = OP_DEACT; nx_dst = DST_PRV; end
        CLS_SHR:  begin nx_op = OP_DEACT; nx_dst = DST_SHR; end
        default:  nx_op = OP_NONE;
      endcase
    end
  end

  assign need_cmd = (nx_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_id   <= ID_SPUR;
      rec_prio <= PRIO_IDLE;
    end else if (ack_fire) begin
      rec_prio <= PRIO_IDLE;
    end else if (seq_upd) begin
      rec_id   <= pk_vld ? pk_id   : ID_SPUR;
      rec_prio <= pk_vld ? pk_prio : PRIO_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_rsp_vld <= 1'b0;
      ack_rsp_id  <= ID_SPUR;
    end else if (ack_fire) begin
      ack_rsp_vld <= 1'b1;
      ack_rsp_id  <= rec_live ? rec_id : ID_SPUR;
    end else if (ack_rsp_rdy) begin
      ack_rsp_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld <= 1'b0;
      cmd_op  <= OP_NONE;
      cmd_dst <= DST_PRV;
      cmd_id  <= '0;
    end else if (go && need_cmd) begin
      cmd_vld <= 1'b1;
      cmd_op  <= nx_op;
      cmd_dst <= nx_dst;
      cmd_id  <= nx_id;
    end else if (cmd_fire) begin
      cmd_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/cia_checks.sv
module cia_checks #(
  parameter int ID_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            shr_scan_req,
  input logic            shr_scan_done,
  input logic            prv_scan_req,
  input logic            irq_out,
  input logic            ack_vld,
  input logic            ack_rdy,
  input logic            ack_rsp_vld,
  input logic            ack_rsp_rdy,
  input logic [ID_W-1:0] ack_rsp_id,
  input logic            eoi_vld,
  input logic            eoi_rdy,
  input logic            cmd_vld,
  input logic            cmd_rdy,
  input logic [1:0]      cmd_op,
  input logic            cmd_dst,
  input logic [ID_W-1:0] cmd_id
);
  // R2: private request starts only after a completed shared handshake
  a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prv_scan_req) |-> $past(shr_scan_req && shr_scan_done));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shr_scan_req && prv_scan_req));

  // R5: acknowledge drops the request line in the next cycle
  a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_rdy) |=> !irq_out);

  // R7: end-of-interrupt leads to a command or straight to the shared scan
  a_r7_eoi_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && eoi_rdy) |=> (cmd_vld || shr_scan_req));

  // R8: any acknowledge leads to a response and re-evaluation
  a_r8_ack_reeval: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && ack_rdy) |=> (ack_rsp_vld && (cmd_vld || shr_scan_req)));

  // R9: stalled command and response stay stable
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_rdy) |=> (cmd_vld && $stable(cmd_op) && $stable(cmd_dst) && $stable(cmd_id)));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_vld && !ack_rsp_rdy) |=> (ack_rsp_vld && $stable(ack_rsp_id)));

  a_r9_scan_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> !shr_scan_req);

  // R11: acknowledge takes precedence
  a_r11_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> !eoi_rdy);
endmodule

bind core_irq_arbiter cia_checks #(.ID_W(ID_W)) u_cia_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .shr_scan_req  (shr_scan_req),
  .shr_scan_done (shr_scan_done),
  .prv_scan_req  (prv_scan_req),
  .irq_out       (irq_out),
  .ack_vld       (ack_vld),
  .ack_rdy       (ack_rdy),
  .ack_rsp_vld   (ack_rsp_vld),
  .ack_rsp_rdy   (ack_rsp_rdy),
  .ack_rsp_id    (ack_rsp_id),
  .eoi_vld       (eoi_vld),
  .eoi_rdy       (eoi_rdy),
  .cmd_vld       (cmd_vld),
  .cmd_rdy       (cmd_rdy),
  .cmd_op        (cmd_op),
  .cmd_dst       (cmd_dst),
  .cmd_id        (cmd_id)
);

// File: tb/core_irq_arbiter_test.sv
`timescale 1ns/1ps
module core_irq_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        shr_cand_vld = 0, prv_cand_vld = 0;
  logic [15:0] shr_cand_id = 0, prv_cand_id = 0;
  logic [7:0]  shr_cand_prio = 8'hff, prv_cand_prio = 8'hff;
  logic [7:0]  prio_mask = 8'hff;
  logic        src_kick = 0;
  logic        shr_scan_req, prv_scan_req, shr_scan_done, prv_scan_done;
  logic        shr_auto = 1, prv_auto = 1;
  logic        irq_out;
  logic        ack_vld = 0, ack_rdy, ack_rsp_vld, ack_rsp_rdy = 1;
  logic [15:0] ack_rsp_id;
  logic        eoi_vld = 0, eoi_rdy;
  logic [15:0] eoi_id = 0;
  logic        cmd_vld, cmd_rdy = 1, cmd_dst;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_id;

  assign shr_scan_done = shr_scan_req & shr_auto;
  assign prv_scan_done = prv_scan_req & prv_auto;

  core_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .shr_cand_vld(shr_cand_vld), .shr_cand_id(shr_cand_id), .shr_cand_prio(shr_cand_prio),
    .prv_cand_vld(prv_cand_vld), .prv_cand_id(prv_cand_id), .prv_cand_prio(prv_cand_prio),
    .prio_mask(prio_mask), .src_kick(src_kick),
    .shr_scan_req(shr_scan_req), .shr_scan_done(shr_scan_done),
    .prv_scan_req(prv_scan_req), .prv_scan_done(prv_scan_done),
    .irq_out(irq_out),
    .ack_vld(ack_vld), .ack_rdy(ack_rdy), .ack_rsp_vld(ack_rsp_vld),
    .ack_rsp_rdy(ack_rsp_rdy), .ack_rsp_id(ack_rsp_id),
    .eoi_vld(eoi_vld), .eoi_rdy(eoi_rdy), .eoi_id(eoi_id),
    .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy), .cmd_op(cmd_op),
    .cmd_dst(cmd_dst), .cmd_id(cmd_id)
  );

  int n_tests = 0, n_fail = 0;
  int shr_cnt = 0, prv_cnt = 0;
  logic shr_q = 0, prv_q = 0, shr_seen = 0, order_bad = 0;

  // scan order monitor (R2)
  always @(negedge clk) if (rst_n) begin
    if (shr_scan_req && !shr_q) begin shr_cnt++; shr_seen = 1; end
    if (prv_scan_req && !prv_q) begin
      prv_cnt++;
      if (!shr_seen) order_bad = 1;
      shr_seen = 0;
    end
    shr_q = shr_scan_req;
    prv_q = prv_scan_req;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cands(input logic sv, input int sid, input int sp,
                           input logic pv, input int pid, input int pp);
    shr_cand_vld = sv; shr_cand_id = 16'(sid); shr_cand_prio = 8'(sp);
    prv_cand_vld = pv; prv_cand_id = 16'(pid); prv_cand_prio = 8'(pp);
  endtask

  task automatic kick_wait();
    @(negedge clk) src_kick = 1;
    @(negedge clk) src_kick = 0;
    repeat (6) @(negedge clk);
  endtask

  // acknowledge; samples response and command the cycle after acceptance
  task automatic do_ack(output int id, output int cv, output int op, output int dst);
    @(negedge clk) ack_vld = 1;
    @(negedge clk) ack_vld = 0;
    id = ack_rsp_id; cv = cmd_vld; op = cmd_op; dst = cmd_dst;
    repeat (7) @(negedge clk);
  endtask

  task automatic do_eoi(input int id, output int cv, output int op, output int dst, output int cid);
    @(negedge clk) begin eoi_vld = 1; eoi_id = 16'(id); end
    @(negedge clk) eoi_vld = 0;
    cv = cmd_vld; op = cmd_op; dst = cmd_dst; cid = cmd_id;
    repeat (7) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 irq", irq_out, 0);
    chk("R1 ack_rdy", ack_rdy, 1);
    chk("R1 rsp_vld", ack_rsp_vld, 0);
    chk("R1 cmd_vld", cmd_vld, 0);
    chk("R1 scan reqs", {shr_scan_req, prv_scan_req}, 0);
  endtask

  task automatic t_arbitration();
    int id, cv, op, dst, s0;
    set_cands(1, 40, 'h40, 1, 5, 'h20);
    s0 = shr_cnt;
    kick_wait();
    chk("R2 one shared scan per kick", shr_cnt - s0, 1);
    chk("R4 irq with mask ff", irq_out, 1);
    do_ack(id, cv, op, dst);
    chk("R3 private lower prio wins", id, 5);
    chk("R6 private activate op", op, 1);
    chk("R6 private dst", dst, 0);
    set_cands(1, 40, 'h30, 1, 50, 'h30);
    kick_wait();
    do_ack(id, cv, op, dst);
    chk("R3 equal prio lower shared id", id, 40);
    chk("R6 shared activate dst", dst, 1);
    set_cands(1, 60, 'h30, 1, 7, 'h30);
    kick_wait();
    do_ack(id, cv, op, dst);
    chk("R3 equal prio lower private id", id, 7);
    set_cands(1, 100, 'h10, 1, 3, 'h80);
    kick_wait();
    do_ack(id, cv, op, dst);
    chk("R3 shared lower prio wins", id, 100);
    chk("R6 shared activate op", op, 1);
  endtask

  task automatic t_mask();
    int id, cv, op, dst;
    set_cands(1, 100, 'h50, 0, 0, 'hff);
    prio_mask = 8'h50;
    kick_wait();
    chk("R4 prio equal mask no irq", irq_out, 0);
    prio_mask = 8'h51; #1;
    chk("R4 prio below mask irq", irq_out, 1);
    // record must not follow candidates without a re-evaluation
    set_cands(1, 100, 'h50, 1, 2, 'h01);
    repeat (3) @(negedge clk);
    do_ack(id, cv, op, dst);
    chk("R3 record holds between re-evals", id, 100);
    do_ack(id, cv, op, dst);
    chk("R3 reload picks new private", id, 2);
    prio_mask = 8'hff;
    set_cands(1, 70, 'hff, 0, 0, 'hff);
    kick_wait();
    chk("R4 prio ff no irq", irq_out, 0);
  endtask

  task automatic t_msg_and_spurious();
    int id, cv, op, dst, s0;
    set_cands(0, 0, 'hff, 1, 9000, 'h10);
    kick_wait();
    do_ack(id, cv, op, dst);
    chk("R6 message id returned", id, 9000);
    chk("R6 message clear-pending op", op, 3);
    chk("R6 message dst private", dst, 0);
    set_cands(0, 0, 'hff, 1, 1500, 'h10);
    kick_wait();
    do_ack(id, cv, op, dst);
    chk("R6 reserved id returned", id, 1500);
    chk("R6 reserved id no command", cv, 0);
    set_cands(0, 0, 'hff, 0, 0, 'hff);
    kick_wait();
    chk("R8 no winner no irq", irq_out, 0);
    s0 = shr_cnt;
    do_ack(id, cv, op, dst);
    chk("R8 spurious id", id, 1023);
    chk("R8 spurious no command", cv, 0);
    chk("R8 spurious re-eval", shr_cnt - s0, 1);
  endtask

  task automatic t_ack_drop();
    int p0;
    set_cands(1, 33, 'h08, 0, 0, 'hff);
    kick_wait();
    chk("R5 irq before ack", irq_out, 1);
    shr_auto = 0;
    p0 = prv_cnt;
    @(negedge clk) ack_vld = 1;
    @(negedge clk) ack_vld = 0;
    chk("R5 irq low after ack", irq_out, 0);
    repeat (4) @(negedge clk);
    chk("R5 irq stays low before reload", irq_out, 0);
    chk("R2 private waits for shared", prv_cnt - p0, 0);
    shr_auto = 1;
    repeat (6) @(negedge clk);
    chk("R5 irq back after reload", irq_out, 1);
  endtask

  task automatic t_eoi();
    int cv, op, dst, cid, s0;
    do_eoi(20, cv, op, dst, cid);
    chk("R7 private eoi cmd", cv, 1);
    chk("R7 private eoi op", op, 2);
    chk("R7 private eoi dst", dst, 0);
    chk("R7 private eoi id", cid, 20);
    do_eoi(500, cv, op, dst, cid);
    chk("R7 shared eoi op", op, 2);
    chk("R7 shared eoi dst", dst, 1);
    s0 = shr_cnt;
    do_eoi(8500, cv, op, dst, cid);
    chk("R7 message eoi no cmd", cv, 0);
    chk("R7 message eoi re-eval", shr_cnt - s0, 1);
  endtask

  task automatic t_backpressure();
    int s0;
    set_cands(0, 0, 'hff, 1, 12, 'h10);
    kick_wait();
    cmd_rdy = 0;
    s0 = shr_cnt;
    @(negedge clk) ack_vld = 1;
    @(negedge clk) ack_vld = 0;
    repeat (3) @(negedge clk);
    chk("R9 cmd held", cmd_vld, 1);
    chk("R9 cmd id stable", cmd_id, 12);
    chk("R9 no scan before cmd", shr_cnt - s0, 0);
    cmd_rdy = 1;
    repeat (7) @(negedge clk);
    chk("R9 scan after cmd", shr_cnt - s0, 1);
    ack_rsp_rdy = 0;
    @(negedge clk) ack_vld = 1;
    @(negedge clk) ack_vld = 0;
    repeat (8) @(negedge clk);
    chk("R9 rsp held", ack_rsp_vld, 1);
    chk("R9 rsp id stable", ack_rsp_id, 12);
    chk("R9 ack blocked while rsp pending", ack_rdy, 0);
    ack_rsp_rdy = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_rerun();
    int s0, p0;
    s0 = shr_cnt; p0 = prv_cnt;
    shr_auto = 0;
    @(negedge clk) src_kick = 1;
    @(negedge clk) src_kick = 1;
    @(negedge clk) src_kick = 0;
    shr_auto = 1;
    repeat (10) @(negedge clk);
    chk("R10 shared scans", shr_cnt - s0, 2);
    chk("R10 private scans", prv_cnt - p0, 2);
    chk("R2 order kept", order_bad, 0);
  endtask

  task automatic t_precedence();
    @(negedge clk) begin ack_vld = 1; eoi_vld = 1; eoi_id = 16'd20; end
    #1;
    chk("R11 eoi_rdy low with ack", eoi_rdy, 0);
    chk("R11 ack_rdy high", ack_rdy, 1);
    @(negedge clk) begin ack_vld = 0; eoi_vld = 0; end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_arbitration();
    t_mask();
    t_msg_and_spurious();
    t_ack_drop();
    t_eoi();
    t_backpressure();
    t_rerun();
    t_precedence();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule